// File: doc/BRIEF.md
# Thirty-two pin general-purpose I/O controller

This block gives software word-wide register control over thirty-two pads. Each pad has the following per-pin settings:

- an output level;
- a drive-enable bit;
- an open-drain bit;
- two 2-bit routing fields. One field picks where the pad's output level comes from. The other picks where its drive enable comes from. Either can be the controller's own registers or one of three alternate-function sources, which arrive on input ports.

The pad levels are brought in through a two-stage synchronizer, and software reads them as one word.

Pin numbering runs from the top bit down: pin n is bit 31−n of every one-bit-per-pin word and of every 32-bit pad or alternate-source port. Pad outputs and read data are registered. A bus write lands on the clock edge where the strobe is sampled, and the pads follow one clock later. Read data appears one clock after the address is presented.

Word map (word index on `bus_addr`):

| Index | Content |
|-------|---------|
| 0 | output level |
| 1 | drive enable |
| 2 | output routing, pins 0–15 |
| 3 | output routing, pins 16–31 |
| 4 | enable routing, pins 0–15 |
| 5 | enable routing, pins 16–31 |
| 6 | open-drain enable |
| 7 | synchronized pad levels |
| 8–10 | receive storage |
| 11 | reserved |
| 12–17 | input-select storage, as three low/high pairs |

Top module: `gpio_bank32`

## Requirements
- R1: After reset every readable word reads zero and both `pad_oe` and `pad_out` are all zero, so every pad floats.
- R2: Words 0–6, 8–10 and 12–17 hold the last value written with `bus_wr` high. A read of that index presented at one clock edge returns the value on `bus_rdata` after that edge.
- R3: Writes to word 7, to word 11 and to indices 18–31 have no effect. Word 11 and indices 18–31 always read zero.
- R4: Pin n maps to bit 31−n of words 0, 1, 6 and 7 and of every pad and alternate port. Its routing field sits in bits [31−2m : 30−2m] of the low word (m = n) for pins 0–15, or of the high word (m = n−16) for pins 16–31.
- R5: With routing code 00 and open-drain off, `pad_out` follows the output-level bit and `pad_oe` follows the drive-enable bit one clock after the register changes.
- R6: A pin whose enable routing is 00 and whose drive-enable bit is 0 has `pad_oe` low.
- R7: With open-drain on, `pad_out` is 0. `pad_oe` is set only when the selected enable is 1 and the selected level is 0.
- R8: An output routing code k of 1, 2 or 3 takes the pin level from `altk_val`. An enable routing code k takes the enable from `altk_en`. The two fields are chosen independently. A change on an alternate port reaches the pad one clock later.
- R9: A level change on `pad_in` reaches word 7 after two clocks. A read of word 7 held steady shows the old level two clocks after the change and the new level three clocks after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_addr | input | 5 | word index |
| bus_wr | input | 1 | write strobe |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | registered read data |
| pad_in | input | 32 | pad levels, asynchronous |
| alt1_val | input | 32 | alternate source 1 level |
| alt1_en | input | 32 | alternate source 1 enable |
| alt2_val | input | 32 | alternate source 2 level |
| alt2_en | input | 32 | alternate source 2 enable |
| alt3_val | input | 32 | alternate source 3 level |
| alt3_en | input | 32 | alternate source 3 enable |
| pad_out | output | 32 | registered pad output level |
| pad_oe | output | 32 | registered pad drive enable |

## Verification
The pad path is tried with several patterns:

- Split drive and level words, which expose swapped or shifted bits.
- A lone pin 0, which catches a reversed bit order.
- A half-open-drain word combined with an alternating level, which separates push-pull from open-drain handling.
- Repeating routing codes that differ between the low and high halves and between the level field and the enable field, checked against a per-pin model. This shows field placement and the independence of the two selects.

Register tests write a distinct value to every index and also probe the read-only, reserved and unmapped words. The input test reads the pad word cycle by cycle to pin down the synchronizer latency.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 5;
  localparam int NUM_WORDS = 18;
  localparam int SEL_W     = 2;
  localparam int NUM_ALT   = 3;

  localparam logic [ADDR_W-1:0] IX_LEVEL   = 5'd0;
  localparam logic [ADDR_W-1:0] IX_DRIVE   = 5'd1;
  localparam logic [ADDR_W-1:0] IX_OSEL_LO = 5'd2;
  localparam logic [ADDR_W-1:0] IX_OSEL_HI = 5'd3;
  localparam logic [ADDR_W-1:0] IX_ESEL_LO = 5'd4;
  localparam logic [ADDR_W-1:0] IX_ESEL_HI = 5'd5;
  localparam logic [ADDR_W-1:0] IX_ODRAIN  = 5'd6;
  localparam logic [ADDR_W-1:0] IX_PADS    = 5'd7;
  localparam logic [ADDR_W-1:0] IX_RSVD    = 5'd11;

  typedef enum logic [SEL_W-1:0] {
    SRC_GPIO = 2'd0,
    SRC_ALT1 = 2'd1,
    SRC_ALT2 = 2'd2,
    SRC_ALT3 = 2'd3
  } src_sel_e;

  typedef struct packed {
    logic [WORD_W-1:0] level;
    logic [WORD_W-1:0] drive;
    logic [WORD_W-1:0] osel_lo;
    logic [WORD_W-1:0] osel_hi;
    logic [WORD_W-1:0] esel_lo;
    logic [WORD_W-1:0] esel_hi;
    logic [WORD_W-1:0] odrain;
  } pin_cfg_t;

  function automatic logic word_writable(input logic [ADDR_W-1:0] ix);
    return (ix < NUM_WORDS) && (ix != IX_PADS) && (ix != IX_RSVD);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

  AST_SYNC_TWO_CLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (stage2_q == $past(async_in, 2))); // R9
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] pads_sync,
  output logic [WORD_W-1:0] bus_rdata,
  output pin_cfg_t          cfg
);
  logic [WORD_W-1:0] words_q [NUM_WORDS];
  logic [WORD_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) words_q[i] <= '0;
    end else if (bus_wr && word_writable(bus_addr)) begin
      words_q[bus_addr] <= bus_wdata;
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == IX_PADS)
      rd_next = pads_sync;
    else if (word_writable(bus_addr))
      rd_next = words_q[bus_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  always_comb begin
    cfg.level   = words_q[IX_LEVEL];
    cfg.drive   = words_q[IX_DRIVE];
    cfg.osel_lo = words_q[IX_OSEL_LO];
    cfg.osel_hi = words_q[IX_OSEL_HI];
    cfg.esel_lo = words_q[IX_ESEL_LO];
    cfg.esel_hi = words_q[IX_ESEL_HI];
    cfg.odrain  = words_q[IX_ODRAIN];
  end

  AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == IX_RSVD && !$past(rst)) |-> (bus_rdata == '0)); // R3
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == IX_LEVEL) |=> (cfg.level == $past(bus_wdata))); // R2
  AST_PADS_WORD_RO: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == IX_PADS) |=> $stable(cfg)); // R3
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  pin_cfg_t                       cfg,
  input  logic [NUM_ALT-1:0][PINS-1:0]   alt_val,
  input  logic [NUM_ALT-1:0][PINS-1:0]   alt_en,
  output logic [PINS-1:0]                pad_out,
  output logic [PINS-1:0]                pad_oe
);
  localparam int HALF = PINS / 2;

  logic [PINS-1:0] out_d;
  logic [PINS-1:0] oe_d;

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    localparam int B  = PINS - 1 - n;
    localparam int FB = WORD_W - 1 - SEL_W * (n % HALF);
    src_sel_e osel;
    src_sel_e esel;
    logic     lvl;
    logic     ena;

    if (n < HALF) begin : g_lo
      assign osel = src_sel_e'(cfg.osel_lo[FB -: SEL_W]);
      assign esel = src_sel_e'(cfg.esel_lo[FB -: SEL_W]);
    end else begin : g_hi
      assign osel = src_sel_e'(cfg.osel_hi[FB -: SEL_W]);
      assign esel = src_sel_e'(cfg.esel_hi[FB -: SEL_W]);
    end

    always_comb begin
      case (osel)
        SRC_ALT1: lvl = alt_val[0][B];
        SRC_ALT2: lvl = alt_val[1][B];
        SRC_ALT3: lvl = alt_val[2][B];
        default:  lvl = cfg.level[B];
      endcase
      case (esel)
        SRC_ALT1: ena = alt_en[0][B];
        SRC_ALT2: ena = alt_en[1][B];
        SRC_ALT3: ena = alt_en[2][B];
        default:  ena = cfg.drive[B];
      endcase
      if (cfg.odrain[B]) begin
        out_d[B] = 1'b0;
        oe_d[B]  = ena & ~lvl;
      end else begin
        out_d[B] = lvl;
        oe_d[B]  = ena;
      end
    end

    AST_FLOAT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
      (esel == SRC_GPIO && !cfg.drive[B]) |=> !pad_oe[B]); // R6
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
      cfg.odrain[B] |=> !pad_out[B]); // R7
    AST_PUSHPULL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      (osel == SRC_GPIO && esel == SRC_GPIO && !cfg.odrain[B])
      |=> (pad_out[B] == $past(cfg.level[B]) && pad_oe[B] == $past(cfg.drive[B]))); // R5
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= out_d;
      pad_oe  <= oe_d;
    end
  end
endmodule

// File: rtl/gpio_bank32.sv
module gpio_bank32
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [WORD_W-1:0] pad_in,
  input  logic [WORD_W-1:0] alt1_val,
  input  logic [WORD_W-1:0] alt1_en,
  input  logic [WORD_W-1:0] alt2_val,
  input  logic [WORD_W-1:0] alt2_en,
  input  logic [WORD_W-1:0] alt3_val,
  input  logic [WORD_W-1:0] alt3_en,
  output logic [WORD_W-1:0] pad_out,
  output logic [WORD_W-1:0] pad_oe
);
  pin_cfg_t                          cfg;
  logic [WORD_W-1:0]                 pads_sync;
  logic [NUM_ALT-1:0][WORD_W-1:0]    alt_val;
  logic [NUM_ALT-1:0][WORD_W-1:0]    alt_en;

  assign alt_val = {alt3_val, alt2_val, alt1_val};
  assign alt_en  = {alt3_en,  alt2_en,  alt1_en};

  gpio_in_sync #(.WIDTH(WORD_W)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (pads_sync)
  );

  gpio_regfile u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pads_sync (pads_sync),
    .bus_rdata (bus_rdata),
    .cfg       (cfg)
  );

  gpio_pin_mux #(.PINS(WORD_W)) u_mux (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg),
    .alt_val (alt_val),
    .alt_en  (alt_en),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );
endmodule

// File: tb/gpio_bank32_bench.sv
module gpio_bank32_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] a1v = '0, a1e = '0, a2v = '0, a2e = '0, a3v = '0, a3e = '0;
  logic [31:0] pad_out, pad_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_lvl = '0, m_drv = '0, m_osl = '0, m_osh = '0, m_esl = '0, m_esh = '0, m_od = '0;

  always #4 clk = ~clk;

  gpio_bank32 u_gpio_bank32 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in),
    .alt1_val(a1v), .alt1_en(a1e), .alt2_val(a2v), .alt2_en(a2e),
    .alt3_val(a3v), .alt3_en(a3e), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller stands at a negedge; returns at the next negedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      5'd0: m_lvl = d;
      5'd1: m_drv = d;
      5'd2: m_osl = d;
      5'd3: m_osh = d;
      5'd4: m_esl = d;
      5'd5: m_esh = d;
      5'd6: m_od  = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // expected pads from the requirement text (R4, R5, R7, R8)
  task automatic expect_pads(output logic [31:0] eo, output logic [31:0] ee);
    for (int n = 0; n < 32; n++) begin
      int b = 31 - n;
      int fb = 31 - 2 * (n % 16);
      logic [1:0] co, ce;
      logic v, e;
      co = (n < 16) ? m_osl[fb -: 2] : m_osh[fb -: 2];
      ce = (n < 16) ? m_esl[fb -: 2] : m_esh[fb -: 2];
      v = (co == 2'd0) ? m_lvl[b] : (co == 2'd1) ? a1v[b] : (co == 2'd2) ? a2v[b] : a3v[b];
      e = (ce == 2'd0) ? m_drv[b] : (ce == 2'd1) ? a1e[b] : (ce == 2'd2) ? a2e[b] : a3e[b];
      eo[b] = m_od[b] ? 1'b0 : v;
      ee[b] = m_od[b] ? (e & ~v) : e;
    end
  endtask

  task automatic check_pads(input string req);
    logic [31:0] eo, ee;
    @(negedge clk);
    expect_pads(eo, ee);
    check({req, " pad_out"}, pad_out, eo);
    check({req, " pad_oe"}, pad_oe, ee);
  endtask

  task automatic clear_cfg();
    for (int a = 0; a < 7; a++) wr(a[4:0], 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    rd(5'd0, d); check("R1 level word", d, 32'h0);
    rd(5'd1, d); check("R1 drive word", d, 32'h0);
    rd(5'd6, d); check("R1 odrain word", d, 32'h0);
    rd(5'd15, d); check("R1 isel word", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    for (int a = 0; a < 18; a++)
      if (a != 7 && a != 11) wr(a[4:0], 32'hC3A50000 ^ (a * 32'h01030507));
    for (int a = 0; a < 18; a++)
      if (a != 7 && a != 11) begin
        rd(a[4:0], d);
        check($sformatf("R2 word %0d", a), d, 32'hC3A50000 ^ (a * 32'h01030507));
      end
    clear_cfg();
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    pad_in = 32'h12345678;
    repeat (3) @(negedge clk);
    wr(5'd7, 32'hFFFFFFFF);
    rd(5'd7, d); check("R3 pad word ignores write", d, 32'h12345678);
    wr(5'd11, 32'hDEADBEEF);
    rd(5'd11, d); check("R3 reserved reads zero", d, 32'h0);
    wr(5'd20, 32'hCAFEF00D);
    rd(5'd20, d); check("R3 unmapped reads zero", d, 32'h0);
    rd(5'd0, d); check("R3 level untouched", d, 32'h0);
    check("R3 pads untouched", pad_oe, 32'h0);
  endtask

  task automatic t_pushpull();
    wr(5'd0, 32'hF0F0_3C00);
    wr(5'd1, 32'hFF00_00FF);
    check_pads("R5 split pattern");
    wr(5'd1, 32'h8000_0000);
    wr(5'd0, 32'h8000_0000);
    check_pads("R4 pin0 msb");
    check("R4 pin0 oe bit31", pad_oe, 32'h8000_0000);
    wr(5'd1, 32'h0);
    wr(5'd0, 32'hFFFF_FFFF);
    check_pads("R6 floating");
    check("R6 all float", pad_oe, 32'h0);
  endtask

  task automatic t_opendrain();
    wr(5'd1, 32'hFFFF_FFFF);
    wr(5'd0, 32'hAAAA_AAAA);
    wr(5'd6, 32'hFFFF_0000);
    check_pads("R7 half drain");
    check("R7 oe literal", pad_oe, 32'h5555_FFFF);
    check("R7 out literal", pad_out, 32'h0000_AAAA);
    clear_cfg();
  endtask

  task automatic t_alt();
    a1v = 32'h1357_9BDF; a1e = 32'hF0F0_F0F0;
    a2v = 32'h2468_ACE0; a2e = 32'h0FF0_0FF0;
    a3v = 32'hFEDC_BA98; a3e = 32'h3333_CCCC;
    wr(5'd0, 32'h5A5A_5A5A);
    wr(5'd1, 32'hA5A5_A5A5);
    wr(5'd2, 32'h1B1B_1B1B);
    wr(5'd3, 32'hE4E4_E4E4);
    wr(5'd4, 32'h5555_5555);
    wr(5'd5, 32'h9C9C_9C9C);
    check_pads("R8 mixed codes");
    // pin 1 level code 01 -> alt1_val bit 30
    check("R8 pin1 level", {31'h0, pad_out[30]}, {31'h0, a1v[30]});
    a1v = ~a1v; a2e = ~a2e; a3v = ~a3v;
    check_pads("R8 alt change");
    wr(5'd6, 32'h0F0F_F00F);
    check_pads("R7 drain on alt");
    clear_cfg();
    check_pads("R1 cleared back");
  endtask

  task automatic t_input();
    logic [31:0] d;
    bus_addr = 5'd7;
    pad_in = 32'h8000_0001;
    @(negedge clk); @(negedge clk);
    d = bus_rdata; check("R9 old level after 2 clocks", d, 32'h1234_5678);
    @(negedge clk);
    d = bus_rdata; check("R9 new level after 3 clocks", d, 32'h8000_0001);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_readonly();
    t_pushpull();
    t_opendrain();
    t_alt();
    t_input();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule